// File: doc/BRIEF.md
# Radio Data Group Assembler

This block builds the 104-bit data groups of a broadcast radio data stream from a set of station fields and hands them, one bit at a time, to a downstream bit consumer such as a differential bi-phase modulator. It carries the program identification code, the program type, the traffic-programme and traffic-announcement flags, the music/speech flag, the mono/stereo flag and an eight-character station name. Only basic tuning groups of type 0, version A are produced. Every group is four 26-bit blocks. Each block is a 16-bit information word followed by a 10-bit protection word. That word is a cyclic-code remainder with a fixed offset for the block position mixed in.

The station name goes out two characters per group. A 2-bit segment address walks through the four character pairs, so a full name takes four groups. All field inputs are captured as a set at the instant a new group is loaded. A group never mixes old and new settings. The traffic-announcement flag has its own toggle input so that it can be flipped at any time. The new value appears from the next group on.

The consumer pulses `bit_ready` to take the bit on `bit_out` while `bit_valid` is high. `first_bit` marks the first bit of each group.

Top module: `rds_group_assembler`

## Requirements
- R1: A group is exactly 104 bits long, made of four 26-bit blocks. `first_bit` is high on the first bit of each group only, and the 105th consumed bit starts a new group.
- R2: Each block is its 16-bit information word followed by a 10-bit protection word. The protection word is the remainder of the word times x^10 modulo x^10+x^8+x^7+x^5+x^4+x^3+1, XORed with a position offset. The offsets are 0x0FC for the first block, 0x198 for the second, 0x168 for the third and 0x1B4 for the fourth.
- R3: The information word of the second block carries these fields, from bit 15 down to bit 0: group type 0000 in bits 15:12, version 0 (A) in bit 11, the traffic-programme flag in bit 10, the 5-bit program type in bits 9:5, the traffic-announcement flag in bit 4, the music/speech flag in bit 3, the decoder-identification bit in bit 2 and the segment address in bits 1:0.
- R4: The information words of the first and third blocks both equal the 16-bit program identification code.
- R5: The information word of the fourth block holds name characters 2s (bits 15:8) and 2s+1 (bits 7:0), where s is the segment address. Character k is `ps_name[63-8k -: 8]`, so character 0 is the leftmost.
- R6: Bits leave most significant first. One bit is consumed on each clock edge where `bit_ready` and `bit_valid` are both high. When `bit_ready` is low, `bit_out` and the position within the group hold.
- R7: The segment address is 0 in the first group after reset and rises by one per group, wrapping from 3 to 0. The decoder-identification bit equals the stereo flag in segment 3 and is 0 in segments 0 to 2.
- R8: A one-cycle pulse on `ta_toggle` inverts the pending traffic-announcement flag, which is 0 after reset. The new value is first sent in the group loaded after the pulse.
- R9: Field inputs are sampled only when a group is loaded. Changes during a group do not alter the bits of that group.
- R10: During reset `bit_valid` and `bit_out` are 0. One clock after reset is released, the first group is loaded and `bit_valid` stays high from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pi_code | input | 16 | Program identification code |
| pty | input | 5 | Program type |
| tp_flag | input | 1 | Traffic-programme flag |
| ms_flag | input | 1 | Music (1) / speech (0) flag |
| stereo_flag | input | 1 | Stereo (1) / mono (0) flag |
| ps_name | input | 64 | Eight-character station name, character 0 in bits 63:56 |
| ta_toggle | input | 1 | One-cycle pulse that inverts the traffic-announcement flag |
| bit_ready | input | 1 | Consumer strobe: take the current bit |
| bit_out | output | 1 | Current serial bit |
| bit_valid | output | 1 | A group is loaded and `bit_out` is meaningful |
| first_bit | output | 1 | Current bit is the first of a group |

## Verification
The in-line assertions check on every cycle that the bit position stays inside the group and advances exactly once per consumed strobe. They also check that the position holds with no strobe, that the position wraps to a group start after the last bit, that the segment address steps by one at each load, and that the pending traffic-announcement flag changes only on a toggle pulse. Only the bench scenarios can show the content of the groups. That covers the protection words and offsets, the field positions in the second block, the character pairs per segment, the decoder-identification bit in the last segment, and the fact that field changes and toggles made mid-group appear one group later.

// File: rtl/rds_pkg.sv
package rds_pkg;
  localparam int INFO_W   = 16;
  localparam int CHK_W    = 10;
  localparam int BLOCKS   = 4;
  localparam int BLOCK_W  = INFO_W + CHK_W;
  localparam int GROUP_W  = BLOCKS * BLOCK_W;
  localparam int PI_W     = 16;
  localparam int PTY_W    = 5;
  localparam int TYPE_W   = 4;
  localparam int CHAR_W   = 8;
  localparam int PS_CHARS = 8;
  localparam int PS_W     = PS_CHARS * CHAR_W;
  localparam int SEG_CNT  = PS_CHARS / 2;
  localparam int SEG_W    = $clog2(SEG_CNT);

  // generator polynomial without its x^10 term
  localparam logic [CHK_W-1:0] GEN_POLY = 10'h1B9;

  // position offsets, first block in the most significant slice
  localparam logic [BLOCKS*CHK_W-1:0] OFFSET_TABLE =
    {10'h0FC, 10'h198, 10'h168, 10'h1B4};

  typedef struct packed {
    logic [PI_W-1:0]  pi;
    logic [PTY_W-1:0] pty;
    logic             tp;
    logic             ta;
    logic             ms;
    logic             stereo;
  } station_fields_t;
endpackage

// File: rtl/rds_checkword.sv
module rds_checkword #(
  parameter int               INFO_W = 16,
  parameter int               CHK_W  = 10,
  parameter logic [CHK_W-1:0] POLY   = 10'h1B9,
  parameter logic [CHK_W-1:0] OFFSET = '0
) (
  input  logic [INFO_W-1:0]       info,
  output logic [INFO_W+CHK_W-1:0] block
);
  logic [CHK_W-1:0] remainder;

  // serial polynomial division unrolled over the information bits
  always_comb begin
    logic [CHK_W-1:0] acc;
    logic             fb;
    acc = '0;
    for (int i = INFO_W - 1; i >= 0; i--) begin
      fb  = info[i] ^ acc[CHK_W-1];
      acc = {acc[CHK_W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    remainder = acc;
  end

  assign block = {info, remainder ^ OFFSET};
endmodule

// File: rtl/rds_block_builder.sv
module rds_block_builder
  import rds_pkg::*;
#(
  parameter int GROUP_TYPE = 0,
  parameter int VERSION_B  = 0
) (
  input  station_fields_t          fld,
  input  logic [PS_W-1:0]          ps_name,
  input  logic [SEG_W-1:0]         seg,
  output logic [BLOCKS*INFO_W-1:0] words
);
  logic [2*CHAR_W-1:0] char_pair;
  logic                di_bit;
  logic [INFO_W-1:0]   type_word;

  always_comb begin
    char_pair = '0;
    for (int s = 0; s < SEG_CNT; s++) begin
      if (seg == SEG_W'(s)) char_pair = ps_name[PS_W-1-2*CHAR_W*s -: 2*CHAR_W];
    end
  end

  // the stereo indication rides on the last segment only
  assign di_bit = fld.stereo & (seg == SEG_W'(SEG_CNT - 1));

  assign type_word = {TYPE_W'(GROUP_TYPE), 1'(VERSION_B), fld.tp, fld.pty,
                      fld.ta, fld.ms, di_bit, seg};

  assign words = {fld.pi, type_word, fld.pi, char_pair};
endmodule

// File: rtl/rds_serializer.sv
module rds_serializer #(
  parameter int GROUP_W = 104
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUP_W-1:0] group_in,
  input  logic               bit_ready,
  output logic               load,
  output logic               bit_out,
  output logic               bit_valid,
  output logic               first_bit
);
  localparam int CNT_W = $clog2(GROUP_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GROUP_W - 1);

  logic [GROUP_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   pos_q, pos_d;
  logic               valid_q, valid_d;
  logic               advance, at_last;

  always_comb begin
    advance = valid_q & bit_ready;
    at_last = (pos_q == LAST_POS);
    load    = ~valid_q | (advance & at_last);
    shreg_d = shreg_q;
    pos_d   = pos_q;
    valid_d = valid_q;
    if (load) begin
      shreg_d = group_in;
      pos_d   = '0;
      valid_d = 1'b1;
    end else if (advance) begin
      shreg_d = {shreg_q[GROUP_W-2:0], 1'b0};
      pos_d   = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      pos_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      pos_q   <= pos_d;
      valid_q <= valid_d;
    end
  end

  assign bit_out   = shreg_q[GROUP_W-1];
  assign bit_valid = valid_q;
  assign first_bit = valid_q & (pos_q == '0);

  AST_POS_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS); // R1
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && bit_ready && pos_q == LAST_POS) |=> first_bit); // R1
  AST_ONE_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && bit_ready && pos_q != LAST_POS) |=> pos_q == $past(pos_q) + 1'b1); // R6
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !bit_ready) |=> ($stable(shreg_q) && $stable(pos_q))); // R6
  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q); // R10
endmodule

// File: rtl/rds_group_assembler.sv
module rds_group_assembler
  import rds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PI_W-1:0]  pi_code,
  input  logic [PTY_W-1:0] pty,
  input  logic             tp_flag,
  input  logic             ms_flag,
  input  logic             stereo_flag,
  input  logic [PS_W-1:0]  ps_name,
  input  logic             ta_toggle,
  input  logic             bit_ready,
  output logic             bit_out,
  output logic             bit_valid,
  output logic             first_bit
);
  logic                     ta_q, ta_d;
  logic [SEG_W-1:0]         seg_q, seg_d;
  logic                     load;
  station_fields_t          fld;
  logic [BLOCKS*INFO_W-1:0] words;
  logic [GROUP_W-1:0]       group_word;

  always_comb begin
    ta_d  = ta_q ^ ta_toggle;
    seg_d = load ? seg_q + 1'b1 : seg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_q  <= 1'b0;
      seg_q <= '0;
    end else begin
      ta_q  <= ta_d;
      seg_q <= seg_d;
    end
  end

  assign fld = '{pi: pi_code, pty: pty, tp: tp_flag, ta: ta_q,
                 ms: ms_flag, stereo: stereo_flag};

  rds_block_builder #(.GROUP_TYPE(0), .VERSION_B(0)) u_builder (
    .fld     (fld),
    .ps_name (ps_name),
    .seg     (seg_q),
    .words   (words)
  );

  for (genvar g = 0; g < BLOCKS; g++) begin : g_blk
    rds_checkword #(
      .INFO_W (INFO_W),
      .CHK_W  (CHK_W),
      .POLY   (GEN_POLY),
      .OFFSET (OFFSET_TABLE[CHK_W*(BLOCKS-1-g) +: CHK_W])
    ) u_chk (
      .info  (words[INFO_W*(BLOCKS-1-g) +: INFO_W]),
      .block (group_word[BLOCK_W*(BLOCKS-1-g) +: BLOCK_W])
    );
  end

  rds_serializer #(.GROUP_W(GROUP_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .group_in  (group_word),
    .bit_ready (bit_ready),
    .load      (load),
    .bit_out   (bit_out),
    .bit_valid (bit_valid),
    .first_bit (first_bit)
  );

  AST_SEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> seg_q == $past(seg_q) + 1'b1); // R7
  AST_SEG_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(seg_q)); // R7
  AST_TA_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ta_toggle |=> ta_q != $past(ta_q)); // R8
  AST_TA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_toggle |=> $stable(ta_q)); // R8
endmodule

// File: tb/rds_group_assembler_test.sv
module rds_group_assembler_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pi_code;
  logic [4:0]  pty;
  logic        tp_flag, ms_flag, stereo_flag;
  logic [63:0] ps_name;
  logic        ta_toggle, bit_ready;
  logic        bit_out, bit_valid, first_bit;

  int errors = 0;
  int checks = 0;
  int ta_model = 0;

  bit    exp_bit_q[$];
  bit    exp_first_q[$];
  string exp_tag_q[$];

  always #5 clk = ~clk;

  rds_group_assembler uut (
    .clk(clk), .rst_n(rst_n), .pi_code(pi_code), .pty(pty),
    .tp_flag(tp_flag), .ms_flag(ms_flag), .stereo_flag(stereo_flag),
    .ps_name(ps_name), .ta_toggle(ta_toggle), .bit_ready(bit_ready),
    .bit_out(bit_out), .bit_valid(bit_valid), .first_bit(first_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // long division of d*x^10 by the generator, then the position offset (R2)
  function automatic logic [25:0] make_block(input logic [15:0] d, input logic [9:0] off);
    logic [25:0] v;
    v = {d, 10'b0};
    for (int b = 25; b >= 10; b--)
      if (v[b]) v = v ^ (26'h5B9 << (b - 10));
    return {d, v[9:0] ^ off};
  endfunction

  function automatic string tag_of(input int pos);
    int blk, k;
    blk = pos / 26;
    k   = 15 - (pos % 26);
    if (pos % 26 >= 16) return "R2";
    if (blk == 0 || blk == 2) return "R4";
    if (blk == 3) return "R5";
    if (k == 4) return "R8";
    if (k == 2 || k <= 1) return "R7";
    return "R3";
  endfunction

  // driver: expected group from the requirements
  task automatic push_group(input int seg);
    logic [15:0]  w2, w4;
    logic [103:0] grp;
    logic         di;
    di  = (seg == 3) ? stereo_flag : 1'b0;
    w2  = {4'b0000, 1'b0, tp_flag, pty, 1'(ta_model), ms_flag, di, 2'(seg)};
    w4  = ps_name[63 - 16*seg -: 16];
    grp = {make_block(pi_code, 10'h0FC), make_block(w2, 10'h198),
           make_block(pi_code, 10'h168), make_block(w4, 10'h1B4)};
    for (int i = 0; i < 104; i++) begin
      exp_bit_q.push_back(grp[103 - i]);
      exp_first_q.push_back(i == 0);
      exp_tag_q.push_back(tag_of(i));
    end
  endtask

  // monitor: consume n bits, optionally with held gaps (R6)
  task automatic drain(input int n, input int gap_every, input string ctx);
    bit eb, ef;
    string t;
    logic held;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_ready = 1'b0;
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) begin
        held = bit_out;
        repeat (2) @(negedge clk);
        check(bit_out === held, {ctx, " R6 hold"}, bit_out, held);
      end
      eb = exp_bit_q.pop_front();
      ef = exp_first_q.pop_front();
      t  = exp_tag_q.pop_front();
      check(bit_valid === 1'b1, {ctx, " R10 valid"}, bit_valid, 1);
      check(bit_out === eb, {ctx, " R6 ", t}, bit_out, eb);
      check(first_bit === ef, {ctx, " R1 first"}, first_bit, ef);
      bit_ready = 1'b1;
    end
    @(negedge clk);
    bit_ready = 1'b0;
  endtask

  task automatic pulse_ta();
    @(negedge clk);
    ta_toggle = 1'b1;
    @(negedge clk);
    ta_toggle = 1'b0;
    ta_model = 1 - ta_model;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bit_ready = 1'b0;
    ta_toggle = 1'b0;
    pi_code = 16'h52A7; pty = 5'd10; tp_flag = 1'b1; ms_flag = 1'b1;
    stereo_flag = 1'b0; ps_name = "RADIO 42";
    repeat (3) @(negedge clk);
    check(bit_valid === 1'b0, "R10 reset valid", bit_valid, 0);
    check(bit_out === 1'b0, "R10 reset bit", bit_out, 0);
    rst_n = 1'b1;

    // group 0: segment 0, TA 0; fields change mid-group (R9)
    push_group(0);
    drain(50, 0, "g0 R9");
    pi_code = 16'hC3F0; pty = 5'd3; tp_flag = 1'b0; ms_flag = 1'b0;
    stereo_flag = 1'b1; ps_name = "NIGHT FM";
    drain(54, 0, "g0 R9");

    // group 1: new fields, consumer with gaps, TA toggled mid-group (R8)
    push_group(1);
    drain(40, 7, "g1 R6");
    pulse_ta();
    drain(64, 7, "g1 R8");

    // group 2: TA now 1
    push_group(2);
    drain(104, 0, "g2 R8");

    // group 3: last segment carries stereo as DI (R7); double toggle leaves TA
    push_group(3);
    drain(30, 0, "g3 R7");
    pulse_ta();
    pulse_ta();
    drain(74, 0, "g3 R7");

    // group 4: segment wraps to 0, DI back to 0; fields change again
    push_group(0);
    drain(60, 0, "g4 R7");
    pi_code = 16'h0001; pty = 5'd31; tp_flag = 1'b1; ms_flag = 1'b1;
    stereo_flag = 1'b0; ps_name = "ZZ-top99";
    pulse_ta();
    drain(44, 0, "g4 R9");

    // group 5: segment 1 with the newest fields, TA 0
    push_group(1);
    drain(104, 3, "g5 R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule